// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block is the acknowledge half of an eight-line interrupt controller. It captures requests in a request register, tracks serviced levels in an in-service register, and picks the winner with a fixed-priority resolver. It raises `int_o` toward the CPU, counts the CPU's acknowledge pulses, and supplies one byte for each pulse on a data bus with a separate output enable.

Two CPU styles are supported, chosen by `three_pulse_i`. In the three-pulse style the block returns a call opcode and then a 16-bit routine address whose low byte carries the interrupt level. In the two-pulse style it leaves the bus undriven on the first pulse and returns an 8-bit vector on the second. The serviced level is retired either automatically at the end of the sequence or by an end-of-interrupt strobe. A request that disappears before the first acknowledge pulse yields a level-7 vector. The mode inputs and `base_i` are held steady while a sequence runs, and `eoi_i` is not pulsed during a sequence.

Top module: `intack_seq`

## Requirements
- R1: After reset, `int_o` and `data_oe_o` are low and both the request and in-service registers are empty.
- R2: A request bit is set by a rising edge on its `irq_i` line and cleared while that line is low. Level 0 ranks highest and level 7 lowest. `int_o` is high when no sequence is running and the best pending level ranks above every in-service level.
- R3: `int_o` goes low after the first falling edge of the synchronised acknowledge and stays low until the sequence ends.
- R4: In three-pulse mode, the first pulse drives 8'hCD.
- R5: In three-pulse mode, the second pulse drives the low address byte. With `step8_i`=0 this byte is {base_i[7:5], level, 2'b00}. With `step8_i`=1 it is {base_i[7:6], level, 3'b000}. The third pulse drives base_i[15:8].
- R6: In two-pulse mode, the bus is not driven during the first pulse. The second pulse drives {base_i[7:3], level}.
- R7: The in-service bit of the acknowledged level is set on a falling acknowledge edge: the second pulse in three-pulse mode, the first pulse in two-pulse mode. The matching request bit is cleared on the rising edge of that same pulse and stays clear while its line remains high. The in-service register changes by at most one bit per cycle.
- R8: With `aeoi_i`=1, the in-service bit is cleared on the rising edge of the last pulse of the sequence.
- R9: With `aeoi_i`=0, the in-service bit stays set until `eoi_i` is pulsed. Each pulse clears the highest-priority in-service bit that is set.
- R10: If no pending request qualifies at the first falling acknowledge edge, the sequence delivers the level-7 vector and leaves both registers unchanged.
- R11: `inta_ni` passes through SYNC_STAGES flops. `data_oe_o` is high only while the synchronised acknowledge is low, a sequence is active and the current pulse carries a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| irq_i | input | 8 | request lines, one per level |
| inta_ni | input | 1 | asynchronous acknowledge from the CPU, active low |
| three_pulse_i | input | 1 | 1: call opcode plus address; 0: single vector byte |
| aeoi_i | input | 1 | retire the in-service bit automatically |
| step8_i | input | 1 | address spacing 8 instead of 4 |
| base_i | input | 16 | programmed address / vector base |
| eoi_i | input | 1 | one-cycle non-specific end-of-interrupt strobe |
| int_o | output | 1 | interrupt request to the CPU |
| data_o | output | 8 | byte for the current acknowledge pulse |
| data_oe_o | output | 1 | drive enable for data_o |

## Verification
The bench runs full acknowledge sequences in both CPU styles and with both address spacings, so that the position of the level field in the low byte can be checked for each case. Other patterns cover a single request, two simultaneous requests (which checks priority), a lower-priority request arriving while a higher level is in service (which checks masking until the end-of-interrupt strobe), and a request line that is held high after acknowledge (which checks that the request bit is cleared on the edge and not set again). A request withdrawn before the first pulse must produce the level-7 vector and must leave the in-service register untouched. This is shown when a later low-priority request is still forwarded.

// File: rtl/intack_pkg.sv
package intack_pkg;
  localparam int unsigned NUM_LVL = 8;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);
  localparam logic [7:0]  CALL_OP = 8'hCD;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_vec_t;
  typedef logic [1:0]         pulse_idx_t;
endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_ni,
  output logic ack_lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b1;
    else         sh_q[0] <= ack_ni;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[g] <= 1'b1;
      else         sh_q[g] <= sh_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sh_q[STAGES-1];
  end

  assign ack_lvl_o = sh_q[STAGES-1];
  assign fall_o    = prev_q & ~sh_q[STAGES-1];
  assign rise_o    = ~prev_q & sh_q[STAGES-1];
endmodule

// File: rtl/prio_res.sv
module prio_res
  import intack_pkg::*;
(
  input  lvl_vec_t vec_i,
  output logic     any_o,
  output lvl_t     lvl_o
);
  // lowest index wins
  always_comb begin
    lvl_o = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (vec_i[i]) lvl_o = lvl_t'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/vec_mux.sv
module vec_mux
  import intack_pkg::*;
(
  input  logic       three_pulse_i,
  input  logic       step8_i,
  input  logic [15:0] base_i,
  input  lvl_t       lvl_i,
  input  pulse_idx_t idx_i,
  output logic [7:0] byte_o,
  output logic       due_o
);
  always_comb begin
    byte_o = '0;
    due_o  = 1'b0;
    if (three_pulse_i) begin
      due_o = 1'b1;
      unique case (idx_i)
        2'd0:    byte_o = CALL_OP;
        2'd1:    byte_o = step8_i ? {base_i[7:6], lvl_i, 3'b000}
                                  : {base_i[7:5], lvl_i, 2'b00};
        default: byte_o = base_i[15:8];
      endcase
    end else if (idx_i == 2'd1) begin
      due_o  = 1'b1;
      byte_o = {base_i[7:3], lvl_i};
    end
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  irq_i,
  input  logic        inta_ni,
  input  logic        three_pulse_i,
  input  logic        aeoi_i,
  input  logic        step8_i,
  input  logic [15:0] base_i,
  input  logic        eoi_i,
  output logic        int_o,
  output logic [7:0]  data_o,
  output logic        data_oe_o
);
  logic ack_s, ack_fall, ack_rise;
  lvl_vec_t irq_q, irr_q, isr_q, irr_n, isr_n;
  logic busy_q, spur_q;
  pulse_idx_t cnt_q;
  lvl_t lvl_q;
  logic irr_any, isr_any, req_ok, due;
  lvl_t irr_lvl, isr_lvl, set_lvl;
  logic set_now, clr_irr, last_rise;
  pulse_idx_t last_idx, irr_idx;

  ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_ni(inta_ni),
    .ack_lvl_o(ack_s), .fall_o(ack_fall), .rise_o(ack_rise)
  );

  prio_res u_req (.vec_i(irr_q), .any_o(irr_any), .lvl_o(irr_lvl));
  prio_res u_svc (.vec_i(isr_q), .any_o(isr_any), .lvl_o(isr_lvl));

  assign req_ok   = irr_any && (!isr_any || irr_lvl < isr_lvl);
  assign last_idx = three_pulse_i ? 2'd2 : 2'd1;
  assign irr_idx  = three_pulse_i ? 2'd1 : 2'd0;

  // ISR set: two-pulse on first fall, three-pulse on second fall
  assign set_now = ack_fall & ((~busy_q & ~three_pulse_i & req_ok) |
                               (busy_q & three_pulse_i & (cnt_q == 2'd1) & ~spur_q));
  assign set_lvl   = busy_q ? lvl_q : irr_lvl;
  assign clr_irr   = ack_rise & busy_q & ~spur_q & (cnt_q == irr_idx);
  assign last_rise = ack_rise & busy_q & (cnt_q == last_idx);

  always_comb begin
    irr_n = (irr_q | (irq_i & ~irq_q)) & irq_i;
    if (clr_irr) irr_n[lvl_q] = 1'b0;
  end

  always_comb begin
    isr_n = isr_q;
    if (eoi_i && isr_any)              isr_n[isr_lvl] = 1'b0;
    if (last_rise && aeoi_i && !spur_q) isr_n[lvl_q]  = 1'b0;
    if (set_now)                        isr_n[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irq_q <= irq_i;
      irr_q <= irr_n;
      isr_q <= isr_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lvl_q  <= '0;
      spur_q <= 1'b0;
    end else if (ack_fall && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      lvl_q  <= req_ok ? irr_lvl : lvl_t'(NUM_LVL - 1);
      spur_q <= ~req_ok;
    end else if (ack_rise && busy_q) begin
      if (cnt_q == last_idx) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  vec_mux u_vec (
    .three_pulse_i(three_pulse_i), .step8_i(step8_i), .base_i(base_i),
    .lvl_i(lvl_q), .idx_i(cnt_q), .byte_o(data_o), .due_o(due)
  );

  assign int_o     = ~busy_q & req_ok;
  assign data_oe_o = ~ack_s & busy_q & due;
endmodule

// File: rtl/intack_chk.sv
module intack_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        three_pulse_i,
  input logic [15:0] base_i,
  input logic        int_o,
  input logic [7:0]  data_o,
  input logic        data_oe_o,
  input logic [7:0]  isr_q,
  input logic        ack_fall
);
  // R7
  isr_set_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((isr_q & ~$past(isr_q)) != 8'h00) |-> $past(ack_fall));

  // R7
  isr_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q ^ $past(isr_q)) <= 1);

  // R6
  two_pulse_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !three_pulse_i) |-> (data_o[7:3] == base_i[7:3]));

  // R3
  int_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && ack_fall) |=> !int_o);

  // R4
  call_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(data_oe_o) && three_pulse_i && $past(ack_fall) && $past(int_o))
      |-> (data_o == 8'hCD));
endmodule

bind intack_seq intack_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .three_pulse_i(three_pulse_i),
  .base_i(base_i), .int_o(int_o), .data_o(data_o), .data_oe_o(data_oe_o),
  .isr_q(isr_q), .ack_fall(ack_fall)
);

// File: tb/sim_intack_seq.sv
module sim_intack_seq;
  localparam int SYNC = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic inta_n = 1'b1;
  logic mode3 = 1'b0, aeoi = 1'b0, step8 = 1'b0, eoi = 1'b0;
  logic [15:0] base = '0;
  logic int_w, oe_w;
  logic [7:0] data_w;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  intack_seq #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .inta_ni(inta_n),
    .three_pulse_i(mode3), .aeoi_i(aeoi), .step8_i(step8), .base_i(base),
    .eoi_i(eoi), .int_o(int_w), .data_o(data_w), .data_oe_o(oe_w)
  );

  // behavioural reference
  logic [7:0] m_irr, m_isr, m_irqp;
  bit m_busy, m_spur, m_s, m_sp;
  int m_cnt, m_lvl;
  bit q[$];

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit m_ok();
    int p = lowest(m_irr);
    return p < 8 && p < lowest(m_isr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_irqp = 0; m_busy = 0; m_spur = 0;
      m_cnt = 0; m_lvl = 0; m_s = 1; m_sp = 1;
      q = {};
      for (int i = 0; i < SYNC - 1; i++) q.push_back(1'b1);
    end else begin
      bit fall, rise, ok;
      int p, t;
      logic [7:0] nirr, nisr;
      fall = m_sp && !m_s;
      rise = !m_sp && m_s;
      p = lowest(m_irr); t = lowest(m_isr); ok = m_ok();
      nirr = (m_irr | (irq & ~m_irqp)) & irq;
      nisr = m_isr;
      if (eoi && t < 8) nisr[t] = 1'b0;
      if (m_busy && rise) begin
        if (!m_spur && m_cnt == (mode3 ? 1 : 0)) nirr[m_lvl] = 1'b0;
        if (m_cnt == (mode3 ? 2 : 1)) begin
          if (aeoi && !m_spur) nisr[m_lvl] = 1'b0;
          m_busy = 0; m_cnt = 0;
        end else m_cnt++;
      end
      if (fall) begin
        if (!m_busy) begin
          if (!mode3 && ok) nisr[p] = 1'b1;
          m_lvl = ok ? p : 7; m_spur = !ok; m_busy = 1; m_cnt = 0;
        end else if (mode3 && m_cnt == 1 && !m_spur) nisr[m_lvl] = 1'b1;
      end
      m_irr = nirr; m_isr = nisr; m_irqp = irq;
      m_sp = m_s; m_s = q.pop_front(); q.push_back(inta_n);
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_oe;
      logic [7:0] e_d;
      e_oe = !m_s && m_busy && (mode3 || m_cnt == 1);
      if (mode3) begin
        if (m_cnt == 0)      e_d = 8'hCD;
        else if (m_cnt == 1) e_d = step8 ? ((base[7:0] & 8'hC0) | 8'(m_lvl << 3))
                                         : ((base[7:0] & 8'hE0) | 8'(m_lvl << 2));
        else                 e_d = base[15:8];
      end else e_d = (base[7:0] & 8'hF8) | 8'(m_lvl);
      check("R2 int_o", {15'd0, int_w}, {15'd0, !m_busy && m_ok()});
      check("R11 data_oe_o", {15'd0, oe_w}, {15'd0, e_oe});
      if (e_oe) check("R5 data_o", {8'd0, data_w}, {8'd0, e_d});
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse(input bit exp_oe, input logic [7:0] exp_d, input string tag);
    inta_n = 1'b0;
    wait_n(4);
    check({tag, " oe"}, {15'd0, oe_w}, {15'd0, exp_oe});
    if (exp_oe) check({tag, " byte"}, {8'd0, data_w}, {8'd0, exp_d});
    inta_n = 1'b1;
    wait_n(5);
  endtask

  task automatic eoi_pulse();
    eoi = 1'b1; wait_n(1); eoi = 1'b0; wait_n(2);
  endtask

  initial begin
    wait_n(3);
    check("R1 int_o", {15'd0, int_w}, 16'd0);
    check("R1 data_oe_o", {15'd0, oe_w}, 16'd0);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 idle after reset", {14'd0, int_w, oe_w}, 16'd0);

    // three-pulse, spacing 4, level 3
    mode3 = 1; step8 = 0; aeoi = 0; base = 16'h12E0;
    irq = 8'h08; wait_n(3);
    check("R2 int raised", {15'd0, int_w}, 16'd1);
    ack_pulse(1, 8'hCD, "R4");
    check("R3 int low in sequence", {15'd0, int_w}, 16'd0);
    ack_pulse(1, 8'hEC, "R5 step4");
    ack_pulse(1, 8'h12, "R5 high");
    irq = 8'h00;
    irq = 8'h20; wait_n(3);
    check("R9 lower level masked", {15'd0, int_w}, 16'd0);
    eoi_pulse();
    check("R9 eoi releases", {15'd0, int_w}, 16'd1);

    // three-pulse, spacing 8, level 5
    step8 = 1;
    ack_pulse(1, 8'hCD, "R4");
    ack_pulse(1, 8'hE8, "R5 step8");
    ack_pulse(1, 8'h12, "R5 high");
    irq = 8'h00; wait_n(2);
    eoi_pulse();

    // two-pulse with AEOI, line kept high after acknowledge
    mode3 = 0; aeoi = 1; base = 16'h0048;
    irq = 8'h04; wait_n(3);
    ack_pulse(0, 8'h00, "R6 first");
    ack_pulse(1, 8'h4A, "R6 vector");
    check("R7 request cleared while line high", {15'd0, int_w}, 16'd0);
    irq = 8'h44; wait_n(3);
    check("R8 isr retired", {15'd0, int_w}, 16'd1);
    ack_pulse(0, 8'h00, "R6 first");
    ack_pulse(1, 8'h4E, "R6 vector");
    irq = 8'h00; wait_n(2);

    // withdrawn request, no AEOI
    aeoi = 0;
    irq = 8'h10; wait_n(3);
    check("R2 int raised", {15'd0, int_w}, 16'd1);
    irq = 8'h00; wait_n(2);
    check("R10 withdrawn", {15'd0, int_w}, 16'd0);
    ack_pulse(0, 8'h00, "R10 first");
    ack_pulse(1, 8'h4F, "R10 level7");
    irq = 8'h80; wait_n(3);
    check("R10 isr untouched", {15'd0, int_w}, 16'd1);
    irq = 8'h00; wait_n(2);

    // priority between two simultaneous requests, AEOI, spacing 8
    mode3 = 1; step8 = 1; aeoi = 1; base = 16'h12E0;
    irq = 8'h90; wait_n(3);
    ack_pulse(1, 8'hCD, "R4");
    ack_pulse(1, 8'hE0, "R2 priority");
    ack_pulse(1, 8'h12, "R5 high");
    check("R8 next level follows", {15'd0, int_w}, 16'd1);
    ack_pulse(1, 8'hCD, "R4");
    ack_pulse(1, 8'hF8, "R5 level7");
    ack_pulse(1, 8'h12, "R5 high");
    irq = 8'h00; wait_n(4);
    check("R7 all serviced", {15'd0, int_w}, 16'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule